// File: doc/BRIEF.md
# Paged RAM address translator

This block sits between the CPU and the RAM array and turns CPU logical addresses into physical RAM addresses. It keeps a page map of 1024 sixteen-bit entries on chip. When an access falls in the low 4 MB, the page number taken from the address selects an entry. The entry's physical page number replaces the logical page, and the 12-bit offset within the page is kept as it is. On the same pass the entry's two status bits are updated, so software can later see which pages were touched and which were modified.

The CPU also reaches the page map itself through a window in the I/O region. It can read or write single bytes or whole words there, and each entry is stored high byte first. A boot-map control bit forces address bit 23 high while it is clear, so that every access lands in ROM. A write to a dedicated control page loads this bit. Accesses outside the translated range, the map window and the control page go through to the RAM side unchanged. The translated address comes out one cycle after the request.

Top module: `page_xlate_top`

## Requirements
- R1: After reset both `mem_valid` and `map_rvalid` are low and the boot-map bit is clear. While that bit is clear, address bit 23 of every request is forced to 1 before decoding, so a request for 0x003456 leaves as 0x803456.
- R2: A write whose effective address has bits 23:12 equal to 0xE43 loads the boot-map bit from `cpu_wdata[15]`. Data bit 15 clear leaves the forcing active, and data bit 15 set turns it off. Such a write raises neither `mem_valid` nor `map_rvalid`.
- R3: For an effective address with bits 23:22 equal to zero, the output address is {2'b00, entry[9:0], addr[11:0]}, where the entry is selected by address bits 21:12.
- R4: An effective address with bits 23:22 nonzero that hits neither the map window nor the control page appears on `mem_addr` unchanged.
- R5: The entry status field is bits 14:13. If it is nonzero, a translated read sets bit 14 and a translated write sets bits 14 and 13. If it is zero, the entry is left unchanged. In both cases the other bits are never altered.
- R6: Map window accesses are big-endian. An even byte address selects entry bits 15:8 and an odd one selects bits 7:0. A byte write takes its data from `cpu_wdata[7:0]`. A byte read returns the byte in `map_rdata[7:0]` with the upper bits zero. A word access uses the whole entry and ignores address bit 0.
- R7: Every effective address with bits 23:22 equal to 01 and bits 19:16 equal to zero is a map access, and it selects the entry given by address bits 10:1. Higher window addresses therefore mirror the 2 KB map.
- R8: Each plain request raises `mem_valid`, with `mem_write` copied from the request, exactly one cycle later. Each map read raises `map_rvalid` exactly one cycle later. An idle cycle produces no valid output.
- R9: Back-to-back translated accesses to the same page, and a map read in the cycle right after a translated access, see the status bits set by the earlier access. No update is lost.
- R10: If a CPU map write reaches an entry in the cycle right after a translated access to that entry, the written bytes take the CPU data. Any byte the CPU does not write keeps the status update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Request present this cycle |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| cpu_addr | input | 24 | CPU logical byte address |
| cpu_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| mem_valid | output | 1 | Registered: RAM-side address valid |
| mem_write | output | 1 | Registered: direction of the RAM-side access |
| mem_addr | output | 24 | Registered: translated or passed-through address |
| map_rvalid | output | 1 | Registered: map read data valid |
| map_rdata | output | 16 | Registered: map read data |

## Verification
Directed sequences first check that boot forcing moves a low address into ROM space and that only a control write with data bit 15 set removes the forcing. A table holding every status value is then probed with reads and writes, which separates correct marking from marking that ignores the not-present code or sets the dirty bit on reads. Back-to-back pairs on one page, some of them followed at once by a CPU byte or word write, show whether a deferred status write-back is forwarded and yields correctly to the CPU. A seeded random mix of translated accesses, passthrough accesses and map byte and word accesses at mirrored addresses is compared against a bench model, and a full readback of the table at the end exposes any status bit that was lost or set wrongly.

// File: rtl/pgx_pkg.sv
package pgx_pkg;

  localparam int unsigned ENTRY_W = 16;
  localparam int unsigned ST_HI   = 14;  // accessed
  localparam int unsigned ST_LO   = 13;  // dirty (set together with accessed)

  typedef enum logic [1:0] {
    RGN_PLAIN = 2'd0,
    RGN_MAP   = 2'd1,
    RGN_CTRL  = 2'd2
  } rgn_e;

  // Status marking applied by a translated access to a present page
  function automatic logic [ENTRY_W-1:0] mark_status(input logic [ENTRY_W-1:0] e,
                                                      input logic              wr);
    logic [ENTRY_W-1:0] r;
    r        = e;
    r[ST_HI] = 1'b1;
    if (wr) r[ST_LO] = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/pgx_decode.sv
module pgx_decode
  import pgx_pkg::*;
#(
  parameter int unsigned ADDR_W      = 24,
  parameter int unsigned PAGE_BITS   = 10,
  parameter int unsigned OFFSET_BITS = 12,
  parameter logic [11:0] CTRL_PAGE   = 12'hE43
) (
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              boot_en,
  output logic [ADDR_W-1:0] eff_addr,
  output rgn_e              region,
  output logic              xlate
);

  localparam int unsigned XLAT_TOP = PAGE_BITS + OFFSET_BITS;
  localparam int unsigned TAG_W    = ADDR_W - XLAT_TOP;
  localparam int unsigned WIN_HI   = XLAT_TOP - 3;
  localparam int unsigned WIN_LO   = XLAT_TOP - 6;

  logic [ADDR_W-1:0] force_mask;
  logic [TAG_W-1:0]  tag;

  always_comb begin
    force_mask           = '0;
    force_mask[ADDR_W-1] = ~boot_en;
    eff_addr             = cpu_addr | force_mask;
    tag                  = eff_addr[ADDR_W-1:XLAT_TOP];
    xlate                = (tag == '0);
    if (eff_addr[ADDR_W-1:ADDR_W-12] == CTRL_PAGE)
      region = RGN_CTRL;
    else if ((tag == TAG_W'(1)) && (eff_addr[WIN_HI:WIN_LO] == '0))
      region = RGN_MAP;
    else
      region = RGN_PLAIN;
  end

endmodule

// File: rtl/pgx_map_store.sv
module pgx_map_store
  import pgx_pkg::*;
#(
  parameter int unsigned PAGE_BITS = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PAGE_BITS-1:0] acc_idx,
  input  logic                 xl_en,
  input  logic                 xl_write,
  input  logic                 mw_en,
  input  logic                 mw_hi,
  input  logic                 mw_lo,
  input  logic [ENTRY_W-1:0]   mw_data,
  output logic [ENTRY_W-1:0]   acc_entry
);

  localparam int unsigned DEPTH = 1 << PAGE_BITS;

  logic [ENTRY_W-1:0]   tbl [DEPTH];

  // deferred status write-back
  logic                 pend_q,     pend_d;
  logic [PAGE_BITS-1:0] pend_idx_q, pend_idx_d;
  logic [ENTRY_W-1:0]   pend_val_q, pend_val_d;

  logic                 hit;
  logic                 present;
  logic                 retire;
  logic [ENTRY_W-1:0]   merged;

  always_comb begin
    hit        = pend_q && (pend_idx_q == acc_idx);
    acc_entry  = hit ? pend_val_q : tbl[acc_idx];
    present    = (acc_entry[ST_HI:ST_LO] != 2'b00);
    pend_d     = xl_en && present;
    pend_idx_d = acc_idx;
    pend_val_d = mark_status(acc_entry, xl_write);
    merged     = acc_entry;
    if (mw_hi) merged[15:8] = mw_data[15:8];
    if (mw_lo) merged[7:0]  = mw_data[7:0];
    // a CPU write to the same entry supersedes the pending update
    retire     = pend_q && !(mw_en && hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      pend_idx_q <= '0;
      pend_val_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (pend_d) begin
        pend_idx_q <= pend_idx_d;
        pend_val_q <= pend_val_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (retire) tbl[pend_idx_q] <= pend_val_q;
    if (mw_en)  tbl[acc_idx]    <= merged;
  end

  // R5: a pending status update only ever follows a translated access
  a_r5_pend_origin: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> $past(xl_en));

endmodule

// File: rtl/pgx_out_stage.sv
module pgx_out_stage
  import pgx_pkg::*;
#(
  parameter int unsigned ADDR_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mem_valid_d,
  input  logic               mem_write_d,
  input  logic [ADDR_W-1:0]  mem_addr_d,
  input  logic               map_rvalid_d,
  input  logic [ENTRY_W-1:0] map_rdata_d,
  output logic               mem_valid_q,
  output logic               mem_write_q,
  output logic [ADDR_W-1:0]  mem_addr_q,
  output logic               map_rvalid_q,
  output logic [ENTRY_W-1:0] map_rdata_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_valid_q  <= 1'b0;
      mem_write_q  <= 1'b0;
      mem_addr_q   <= '0;
      map_rvalid_q <= 1'b0;
      map_rdata_q  <= '0;
    end else begin
      mem_valid_q  <= mem_valid_d;
      map_rvalid_q <= map_rvalid_d;
      if (mem_valid_d) begin
        mem_write_q <= mem_write_d;
        mem_addr_q  <= mem_addr_d;
      end
      if (map_rvalid_d) map_rdata_q <= map_rdata_d;
    end
  end

endmodule

// File: rtl/page_xlate_top.sv
module page_xlate_top
  import pgx_pkg::*;
#(
  parameter int unsigned ADDR_W      = 24,
  parameter int unsigned PAGE_BITS   = 10,
  parameter int unsigned OFFSET_BITS = 12,
  parameter logic [11:0] CTRL_PAGE   = 12'hE43
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_valid,
  input  logic               cpu_write,
  input  logic               cpu_word,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [ENTRY_W-1:0] cpu_wdata,
  output logic               mem_valid,
  output logic               mem_write,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic               map_rvalid,
  output logic [ENTRY_W-1:0] map_rdata
);

  localparam int unsigned XLAT_TOP = PAGE_BITS + OFFSET_BITS;
  localparam int unsigned PHYS_PAD = ADDR_W - XLAT_TOP;

  logic                 boot_q, boot_d;
  logic [ADDR_W-1:0]    eff_addr;
  rgn_e                 region;
  logic                 xlate;

  logic                 is_plain, is_map, is_ctrl_wr;
  logic [PAGE_BITS-1:0] acc_idx;
  logic                 xl_en, mw_en, mw_hi, mw_lo;
  logic [ENTRY_W-1:0]   mw_data;
  logic [ENTRY_W-1:0]   acc_entry;
  logic [ADDR_W-1:0]    mem_addr_d;
  logic                 map_rvalid_d;
  logic [ENTRY_W-1:0]   map_rdata_d;

  pgx_decode #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS),
    .OFFSET_BITS(OFFSET_BITS), .CTRL_PAGE(CTRL_PAGE)
  ) u_decode (
    .cpu_addr(cpu_addr), .boot_en(boot_q),
    .eff_addr(eff_addr), .region(region), .xlate(xlate)
  );

  always_comb begin
    is_plain     = cpu_valid && (region == RGN_PLAIN);
    is_map       = cpu_valid && (region == RGN_MAP);
    is_ctrl_wr   = cpu_valid && cpu_write && (region == RGN_CTRL);
    acc_idx      = is_map ? eff_addr[PAGE_BITS:1]
                          : eff_addr[XLAT_TOP-1:OFFSET_BITS];
    xl_en        = is_plain && xlate;
    mw_en        = is_map && cpu_write;
    mw_hi        = cpu_word || !eff_addr[0];
    mw_lo        = cpu_word ||  eff_addr[0];
    mw_data      = cpu_word ? cpu_wdata : {2{cpu_wdata[7:0]}};
    mem_addr_d   = xlate ? {{PHYS_PAD{1'b0}}, acc_entry[PAGE_BITS-1:0],
                            eff_addr[OFFSET_BITS-1:0]}
                         : eff_addr;
    map_rvalid_d = is_map && !cpu_write;
    map_rdata_d  = cpu_word ? acc_entry
                            : {8'h00, (eff_addr[0] ? acc_entry[7:0] : acc_entry[15:8])};
    boot_d       = is_ctrl_wr ? cpu_wdata[15] : boot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) boot_q <= 1'b0;
    else        boot_q <= boot_d;
  end

  pgx_map_store #(.PAGE_BITS(PAGE_BITS)) u_store (
    .clk(clk), .rst_n(rst_n),
    .acc_idx(acc_idx), .xl_en(xl_en), .xl_write(cpu_write),
    .mw_en(mw_en), .mw_hi(mw_hi), .mw_lo(mw_lo), .mw_data(mw_data),
    .acc_entry(acc_entry)
  );

  pgx_out_stage #(.ADDR_W(ADDR_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .mem_valid_d(is_plain), .mem_write_d(cpu_write), .mem_addr_d(mem_addr_d),
    .map_rvalid_d(map_rvalid_d), .map_rdata_d(map_rdata_d),
    .mem_valid_q(mem_valid), .mem_write_q(mem_write), .mem_addr_q(mem_addr),
    .map_rvalid_q(map_rvalid), .map_rdata_q(map_rdata)
  );

  // R8: plain request yields a RAM-side address one cycle later
  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && region == RGN_PLAIN) |=> mem_valid);

  // R8: idle cycle produces no valid output
  a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_valid |=> (!mem_valid && !map_rvalid));

  // R3: page offset carried through untouched
  a_r3_offset: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr[OFFSET_BITS-1:0] == $past(cpu_addr[OFFSET_BITS-1:0])));

  // R6: RAM side and map read side never both respond
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_valid, map_rvalid}));

  // R2: control write is silent on both outputs
  a_r2_ctrl_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_write && region == RGN_CTRL) |=> (!mem_valid && !map_rvalid));

endmodule

// File: tb/tb_page_xlate_top.sv
`timescale 1ns/1ps
module tb_page_xlate_top;

  localparam int WD_CYCLES = 150000;

  logic        clk;
  logic        rst_n;
  logic        cpu_valid, cpu_write, cpu_word;
  logic [23:0] cpu_addr;
  logic [15:0] cpu_wdata;
  logic        mem_valid, mem_write, map_rvalid;
  logic [23:0] mem_addr;
  logic [15:0] map_rdata;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  logic [15:0] mdl [1024];
  logic        mdl_boot;

  page_xlate_top dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_word(cpu_word),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .map_rvalid(map_rvalid), .map_rdata(map_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input string what,
                     input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [23:0] eff_of(input logic [23:0] a);
    return mdl_boot ? a : (a | 24'h800000);
  endfunction

  // 0 plain, 1 map window, 2 control page
  function automatic int rgn_of(input logic [23:0] e);
    if (e[23:12] == 12'hE43) return 2;
    if (e[23:22] == 2'b01 && e[19:16] == 4'h0) return 1;
    return 0;
  endfunction

  function automatic logic [15:0] init_entry(input int i);
    logic [9:0] ph;
    ph = 10'((i * 37 + 5) & 10'h3FF);
    return {i[4], i[1:0], 3'b000, ph};
  endfunction

  // one request; called at a negedge, returns at the next negedge
  task automatic issue(input logic wr, input logic word, input logic [23:0] a,
                       input logic [15:0] d, input string tag);
    logic [23:0] e, exp_ma;
    logic [15:0] exp_rd;
    logic        exp_mv, exp_rv;
    logic [9:0]  idx;
    int          rg;
    cpu_valid = 1'b1; cpu_write = wr; cpu_word = word; cpu_addr = a; cpu_wdata = d;
    e = eff_of(a); rg = rgn_of(e);
    exp_mv = (rg == 0); exp_rv = (rg == 1) && !wr; exp_ma = '0; exp_rd = '0;
    if (rg == 0) begin
      if (e[23:22] == 2'b00) begin
        idx = e[21:12];
        exp_ma = {2'b00, mdl[idx][9:0], e[11:0]};
        if (mdl[idx][14:13] != 2'b00) begin
          mdl[idx][14] = 1'b1;
          if (wr) mdl[idx][13] = 1'b1;
        end
      end else exp_ma = e;
    end else if (rg == 1) begin
      idx = e[10:1];
      if (!wr) exp_rd = word ? mdl[idx] : {8'h00, (e[0] ? mdl[idx][7:0] : mdl[idx][15:8])};
      else if (word) mdl[idx] = d;
      else if (e[0]) mdl[idx][7:0] = d[7:0];
      else mdl[idx][15:8] = d[7:0];
    end else if (wr) mdl_boot = d[15];
    @(posedge clk); @(negedge clk);
    cpu_valid = 1'b0;
    chk("R8", "mem_valid", {23'h0, mem_valid}, {23'h0, exp_mv});
    chk("R8", "map_rvalid", {23'h0, map_rvalid}, {23'h0, exp_rv});
    if (exp_mv) begin
      chk(tag, "mem_addr", mem_addr, exp_ma);
      chk("R8", "mem_write", {23'h0, mem_write}, {23'h0, wr});
    end
    if (exp_rv) chk(tag, "map_rdata", {8'h0, map_rdata}, {8'h0, exp_rd});
  endtask

  task automatic idle(input int n);
    cpu_valid = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(posedge clk); @(negedge clk);
      chk("R8", "idle mem_valid", {23'h0, mem_valid}, 24'h0);
      chk("R8", "idle map_rvalid", {23'h0, map_rvalid}, 24'h0);
    end
  endtask

  initial begin
    #(WD_CYCLES * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    cpu_valid = 0; cpu_write = 0; cpu_word = 0; cpu_addr = '0; cpu_wdata = '0;
    mdl_boot = 1'b0;
    for (int i = 0; i < 1024; i++) mdl[i] = init_entry(i);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "reset mem_valid", {23'h0, mem_valid}, 24'h0);
    chk("R1", "reset map_rvalid", {23'h0, map_rvalid}, 24'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: forcing of bit 23 while boot bit is clear
    issue(0, 1, 24'h003456, 16'h0, "R1");
    issue(0, 1, 24'h400010, 16'h0, "R1");
    // R2: data bit 15 clear keeps forcing, set releases it
    issue(1, 1, 24'hE43000, 16'h7FFF, "R2");
    issue(0, 1, 24'h001000, 16'h0, "R2");
    issue(1, 1, 24'h643ABC, 16'h8000, "R2");
    issue(1, 1, 24'hE43002, 16'h8000, "R2");
    idle(2);

    // fill the page map with word writes
    for (int i = 0; i < 1024; i++)
      issue(1, 1, 24'h400000 + 24'(2 * i), init_entry(i), "R6");
    idle(1);

    // R3/R5: one page of each status code, read then write, then read back
    for (int i = 8; i < 12; i++) begin
      issue(0, 1, {2'b00, 10'(i), 12'h7A3}, 16'h0, "R3");
      issue(0, 1, 24'h400000 + 24'(2 * i), 16'h0, "R5");
      issue(1, 0, {2'b00, 10'(i), 12'h001}, 16'h0055, "R3");
      issue(0, 1, 24'h400000 + 24'(2 * i), 16'h0, "R5");
    end
    // R4: passthrough outside translated range
    issue(0, 1, 24'h410000, 16'h0, "R4");
    issue(1, 1, 24'hA12345, 16'h0, "R4");
    issue(0, 0, 24'hFFFFFF, 16'h0, "R4");
    // R6: byte reads and writes big-endian
    issue(0, 0, 24'h400020, 16'h0, "R6");
    issue(0, 0, 24'h400021, 16'h0, "R6");
    issue(1, 0, 24'h400020, 16'h00A5, "R6");
    issue(1, 0, 24'h400023, 16'h003C, "R6");
    issue(0, 1, 24'h400021, 16'h0, "R6");
    issue(0, 1, 24'h400022, 16'h0, "R6");
    // R7: mirrored window addresses
    issue(0, 1, 24'h400820, 16'h0, "R7");
    issue(0, 1, 24'h70F020, 16'h0, "R7");
    issue(0, 0, 24'h5AA823, 16'h0, "R7");
    // R9: back-to-back same page, immediate readback
    issue(0, 1, 24'h005000, 16'h0, "R9");
    issue(1, 1, 24'h005002, 16'h0, "R9");
    issue(0, 1, 24'h40000A, 16'h0, "R9");
    issue(1, 1, 24'h00D010, 16'h0, "R9");
    issue(0, 1, 24'h00D014, 16'h0, "R9");
    issue(0, 1, 24'h40001A, 16'h0, "R9");
    // R10: CPU map write right after a translated access to the same entry
    issue(1, 1, 24'h01D000, 16'h0, "R10");
    issue(1, 0, 24'h40003B, 16'h0077, "R10");
    issue(0, 1, 24'h40003A, 16'h0, "R10");
    issue(0, 1, 24'h01F000, 16'h0, "R10");
    issue(1, 1, 24'h40003E, 16'h1234, "R10");
    issue(0, 1, 24'h40003E, 16'h0, "R10");
    issue(0, 1, 24'h01F000, 16'h0, "R10");
    issue(1, 0, 24'h40003E, 16'h0000, "R10");
    issue(0, 1, 24'h40003E, 16'h0, "R10");
    // R1/R2: clear boot bit again, forced access, then re-enable
    issue(1, 1, 24'hE43000, 16'h0000, "R2");
    issue(0, 1, 24'h012345, 16'h0, "R1");
    issue(1, 1, 24'hE43000, 16'h8000, "R2");
    idle(2);

    // constrained random mix
    for (int k = 0; k < 3000; k++) begin
      int unsigned op;
      logic [23:0] a;
      op = $urandom_range(0, 5);
      case (op)
        0, 1: begin
          a = {2'b00, 22'($urandom)};
          issue(op[0], 1'($urandom), a, 16'($urandom), "R3");
        end
        2: begin
          a = {2'b01, 2'($urandom), 4'h0, 16'($urandom)};
          issue(0, 1'($urandom), a, 16'h0, "R7");
        end
        3: begin
          a = {2'b01, 2'($urandom), 4'h0, 16'($urandom)};
          issue(0, 0, a, 16'h0, "R6");
        end
        4: begin
          a = {2'b01, 2'($urandom), 4'h0, 16'($urandom)};
          issue(1, 1'($urandom), a, 16'($urandom), "R6");
        end
        default: begin
          a = {1'b1, 23'($urandom)};
          if (a[23:12] == 12'hE43) a[12] = 1'b0;
          issue(1'($urandom), 1'($urandom), a, 16'($urandom), "R4");
        end
      endcase
      if ((k % 97) == 0) idle(1);
    end
    idle(1);

    // full readback: accumulated status bits
    for (int i = 0; i < 1024; i++)
      issue(0, 1, 24'h400000 + 24'(2 * i), 16'h0, "R5");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule